// File: doc/BRIEF.md
# Big-Endian Sub-Word Memory Port

This block sits between a 32-bit core and its physical memory. It takes one byte, halfword or word read or write at a time, addressed by byte, and finds which region the address falls in: a window of device registers, the boot ROM, the RAM, or nothing at all. Device accesses are passed out on a separate port together with their width in bits. ROM and RAM accesses go to an internal word store. Sub-word reads pick the right byte lane, and sub-word writes read the old word, merge in the new lanes and write it back.

Byte lanes are big-endian. Offset 0 within a word is bits [31:24] and offset 3 is bits [7:0]. A halfword or word access that is not naturally aligned is refused. The block answers with a fault flag and zero data, touches no memory, and sets an alignment status bit. That bit stays set until it is cleared.

A four-state machine runs each request. `ST_IDLE` accepts a request (transition *accept*) and moves to `ST_DECODE`. From `ST_DECODE` the machine takes one of two paths. It goes to `ST_FETCH` when a ROM read or a RAM access needs the stored word (*fetch*). It goes straight to `ST_RESP` for faults, device accesses, ROM writes and unmapped addresses (*short*). `ST_FETCH` moves to `ST_RESP` (*merge*), performing the RAM write there if there is one. `ST_RESP` shows the response for one cycle and returns to `ST_IDLE` (*retire*).

Top module: `be_mem_port`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, io_valid and align_sticky are 0.
- R2: A request is misaligned when req_size is 2 or 3 (word) with req_addr[1:0] nonzero, or when req_size is 1 (halfword) with req_addr[0] set. A misaligned request responds with rsp_fault=1 and rsp_rdata=0, does not change memory, makes no I/O access, and sets align_sticky. A byte request (req_size 0) never faults.
- R3: align_sticky stays 1 until align_clr is asserted in a cycle in which no new misalignment is being recorded. The clear takes effect at the next clock edge.
- R4: A byte read at offset k = addr[1:0] returns word bits [31-8k:24-8k], zero-extended into rsp_rdata[7:0].
- R5: A halfword read returns word bits [15:0] when addr[1] is 1 and bits [31:16] when addr[1] is 0, zero-extended into rsp_rdata[15:0].
- R6: Byte and halfword writes replace only the addressed lanes of the stored word, taking the new value from the low bits of req_wdata. A word write replaces the whole word.
- R7: Addresses below ROM_BYTES (default 256) are ROM, and ROM word i reads as 32'hC0DE0000 | i[15:0]. Writes to ROM are dropped.
- R8: Addresses in [RAM_BASE, RAM_BASE+RAM_BYTES) (default 0x1000, 1024 bytes) are RAM. Word index = (addr - RAM_BASE)/4.
- R9: The two device windows [IO0_BASE, +IO0_BYTES) (default 0x4000, 256) and [IO1_BASE, +IO1_BYTES) (default 0x1300, 256) take priority over ROM and RAM, so 0x1300..0x13FF is a device address. A device access pulses io_valid for one cycle with the full address, io_size = 8, 16 or 32, and write data held in the low bits of io_wdata. Read data is taken from the low bits of io_rdata in that same cycle.
- R10: Reads from addresses outside every region return 0, and writes there are dropped.
- R11: rsp_valid is a one-cycle pulse and req_ready is 0 from acceptance through the response. rsp_valid is seen in the third cycle after acceptance for ROM reads and RAM accesses, and in the second cycle for all other requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken while req_ready is 1 |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Alignment fault (memory fault abort) |
| rsp_rdata | output | 32 | Read data, right-justified, zero-extended |
| align_clr | input | 1 | Clears align_sticky |
| align_sticky | output | 1 | Sticky alignment fault status |
| io_valid | output | 1 | Device access strobe |
| io_write | output | 1 | Device access is a write |
| io_addr | output | 32 | Device byte address |
| io_wdata | output | 32 | Device write data, right-justified |
| io_size | output | 6 | Device access width in bits: 8, 16 or 32 |
| io_rdata | input | 32 | Device read data, valid while io_valid is 1 |

## Verification
The bound checker watches several things on every cycle. It checks that a response is a single-cycle pulse while the block reports busy. It checks that a faulting response carries zero data, and that a rising status bit always comes with a faulting response. It checks that the status bit falls only after a clear. It checks that every device strobe carries a legal width and an address inside one of the two windows. Only the bench's scenarios can show the rest: correct lane selection and merge results, dropped ROM and unmapped writes, device priority over RAM in the overlapping window, zero reads from unmapped space, and the per-path response latency. For these the bench compares responses against its own model of RAM contents.

// File: rtl/be_mem_pkg.sv
package be_mem_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_ROM,
        RG_RAM,
        RG_IO
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_FETCH,
        ST_RESP
    } state_e;

    function automatic logic [31:0] size_mask(size_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [5:0] size_bits(size_e sz);
        case (sz)
            SZ_BYTE: return 6'd8;
            SZ_HALF: return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [31:0] rom_word(logic [31:0] idx);
        return 32'hC0DE_0000 | (idx & 32'h0000_FFFF);
    endfunction

endpackage

// File: rtl/be_region_dec.sv
module be_region_dec
    import be_mem_pkg::*;
#(
    parameter int unsigned ROM_BYTES = 256,
    parameter logic [31:0] RAM_BASE  = 32'h0000_1000,
    parameter int unsigned RAM_BYTES = 1024,
    parameter logic [31:0] IO0_BASE  = 32'h0000_4000,
    parameter int unsigned IO0_BYTES = 256,
    parameter logic [31:0] IO1_BASE  = 32'h0000_1300,
    parameter int unsigned IO1_BYTES = 256,
    parameter int unsigned ROM_AW    = 6,
    parameter int unsigned RAM_AW    = 8
) (
    input  logic [31:0]       addr,
    output region_e           region,
    output logic [ROM_AW-1:0] rom_idx,
    output logic [RAM_AW-1:0] ram_idx
);
    localparam logic [32:0] RAM_END = 33'(RAM_BASE) + 33'(RAM_BYTES);
    localparam logic [32:0] IO0_END = 33'(IO0_BASE) + 33'(IO0_BYTES);
    localparam logic [32:0] IO1_END = 33'(IO1_BASE) + 33'(IO1_BYTES);

    logic [32:0] a33;
    logic        hit_io0, hit_io1, hit_rom, hit_ram;

    always_comb begin
        a33     = {1'b0, addr};
        hit_io0 = (addr >= IO0_BASE) && (a33 < IO0_END);
        hit_io1 = (addr >= IO1_BASE) && (a33 < IO1_END);
        hit_rom = a33 < 33'(ROM_BYTES);
        hit_ram = (addr >= RAM_BASE) && (a33 < RAM_END);
        // device windows win over both memories
        if (hit_io0 || hit_io1) region = RG_IO;
        else if (hit_rom)       region = RG_ROM;
        else if (hit_ram)       region = RG_RAM;
        else                    region = RG_NONE;
        rom_idx = ROM_AW'(addr >> 2);
        ram_idx = RAM_AW'((addr - RAM_BASE) >> 2);
    end
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
    import be_mem_pkg::*;
(
    input  size_e       size,
    input  logic [1:0]  off,
    input  logic [31:0] word,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic [31:0] merged
);
    logic [4:0]  sh;
    logic [31:0] bmask;

    always_comb begin
        // big-endian: offset 0 is the top byte, so shift by (3 - off) * 8
        sh    = {~off, 3'b000};
        bmask = 32'h0000_00FF << sh;
        unique case (size)
            SZ_BYTE: begin
                rdata  = (word >> sh) & 32'h0000_00FF;
                merged = (word & ~bmask) | ({24'h0, wdata[7:0]} << sh);
            end
            SZ_HALF: begin
                rdata  = off[1] ? {16'h0, word[15:0]} : {16'h0, word[31:16]};
                merged = off[1] ? {word[31:16], wdata[15:0]}
                                : {wdata[15:0], word[15:0]};
            end
            default: begin
                rdata  = word;
                merged = wdata;
            end
        endcase
    end
endmodule

// File: rtl/be_word_store.sv
module be_word_store
    import be_mem_pkg::*;
#(
    parameter int unsigned RAM_WORDS = 256,
    parameter int unsigned ROM_AW    = 6,
    parameter int unsigned RAM_AW    = 8
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic              rd_rom,
    input  logic [ROM_AW-1:0] rd_rom_idx,
    input  logic [RAM_AW-1:0] rd_ram_idx,
    output logic [31:0]       rd_q,
    input  logic              wr_en,
    input  logic [RAM_AW-1:0] wr_idx,
    input  logic [31:0]       wr_data
);
    logic [31:0] ram [RAM_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) ram[wr_idx] <= wr_data;
        if (rd_en) rd_q <= rd_rom ? rom_word(32'(rd_rom_idx)) : ram[rd_ram_idx];
    end
endmodule

// File: rtl/be_mem_port.sv
module be_mem_port
    import be_mem_pkg::*;
#(
    parameter int unsigned ROM_BYTES = 256,
    parameter logic [31:0] RAM_BASE  = 32'h0000_1000,
    parameter int unsigned RAM_BYTES = 1024,
    parameter logic [31:0] IO0_BASE  = 32'h0000_4000,
    parameter int unsigned IO0_BYTES = 256,
    parameter logic [31:0] IO1_BASE  = 32'h0000_1300,
    parameter int unsigned IO1_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic        rsp_fault,
    output logic [31:0] rsp_rdata,
    input  logic        align_clr,
    output logic        align_sticky,
    output logic        io_valid,
    output logic        io_write,
    output logic [31:0] io_addr,
    output logic [31:0] io_wdata,
    output logic [5:0]  io_size,
    input  logic [31:0] io_rdata
);
    localparam int unsigned ROM_WORDS = ROM_BYTES / 4;
    localparam int unsigned RAM_WORDS = RAM_BYTES / 4;
    localparam int unsigned ROM_AW    = (ROM_WORDS > 1) ? $clog2(ROM_WORDS) : 1;
    localparam int unsigned RAM_AW    = (RAM_WORDS > 1) ? $clog2(RAM_WORDS) : 1;

    state_e      st_q, st_d;
    logic        rq_write_q;
    size_e       rq_size_q;
    logic [31:0] rq_addr_q, rq_wdata_q;
    logic [31:0] rsp_data_q;
    logic        rsp_fault_q, sticky_q;

    region_e           region;
    logic [ROM_AW-1:0] rom_idx;
    logic [RAM_AW-1:0] ram_idx;
    logic [31:0]       mem_q, lane_rd, lane_merged;
    logic              misaligned, mem_rd_en, mem_we;

    be_region_dec #(
        .ROM_BYTES(ROM_BYTES), .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES),
        .IO0_BASE(IO0_BASE), .IO0_BYTES(IO0_BYTES),
        .IO1_BASE(IO1_BASE), .IO1_BYTES(IO1_BYTES),
        .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)
    ) u_dec (
        .addr(rq_addr_q), .region(region), .rom_idx(rom_idx), .ram_idx(ram_idx)
    );

    be_lane_unit u_lane (
        .size(rq_size_q), .off(rq_addr_q[1:0]), .word(mem_q),
        .wdata(rq_wdata_q), .rdata(lane_rd), .merged(lane_merged)
    );

    be_word_store #(
        .RAM_WORDS(RAM_WORDS), .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)
    ) u_store (
        .clk(clk), .rd_en(mem_rd_en), .rd_rom(region == RG_ROM),
        .rd_rom_idx(rom_idx), .rd_ram_idx(ram_idx), .rd_q(mem_q),
        .wr_en(mem_we), .wr_idx(ram_idx), .wr_data(lane_merged)
    );

    always_comb begin
        unique case (rq_size_q)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = rq_addr_q[0];
            default: misaligned = rq_addr_q[1:0] != 2'b00;
        endcase
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (req_valid) st_d = ST_DECODE;
            ST_DECODE: begin
                if (misaligned) st_d = ST_RESP;
                else begin
                    unique case (region)
                        RG_RAM:  st_d = ST_FETCH;
                        RG_ROM:  st_d = rq_write_q ? ST_RESP : ST_FETCH;
                        default: st_d = ST_RESP;
                    endcase
                end
            end
            ST_FETCH:  st_d = ST_RESP;
            ST_RESP:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        req_ready    = st_q == ST_IDLE;
        rsp_valid    = st_q == ST_RESP;
        rsp_fault    = rsp_fault_q;
        rsp_rdata    = rsp_data_q;
        align_sticky = sticky_q;
        io_valid     = (st_q == ST_DECODE) && !misaligned && (region == RG_IO);
        io_write     = rq_write_q;
        io_addr      = rq_addr_q;
        io_wdata     = rq_wdata_q & size_mask(rq_size_q);
        io_size      = size_bits(rq_size_q);
        mem_rd_en    = (st_q == ST_DECODE) && !misaligned &&
                       ((region == RG_RAM) || ((region == RG_ROM) && !rq_write_q));
        mem_we       = (st_q == ST_FETCH) && rq_write_q && (region == RG_RAM);
    end

    // request capture, response data and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_write_q  <= 1'b0;
            rq_size_q   <= SZ_BYTE;
            rq_addr_q   <= '0;
            rq_wdata_q  <= '0;
            rsp_data_q  <= '0;
            rsp_fault_q <= 1'b0;
            sticky_q    <= 1'b0;
        end else begin
            if (st_q == ST_IDLE && req_valid) begin
                rq_write_q <= req_write;
                rq_size_q  <= size_e'(req_size);
                rq_addr_q  <= req_addr;
                rq_wdata_q <= req_wdata;
            end
            if (st_q == ST_DECODE) begin
                rsp_fault_q <= misaligned;
                rsp_data_q  <= io_valid && !rq_write_q
                               ? (io_rdata & size_mask(rq_size_q)) : 32'h0;
            end
            if (st_q == ST_FETCH)
                rsp_data_q <= rq_write_q ? 32'h0 : lane_rd;
            if (st_q == ST_DECODE && misaligned) sticky_q <= 1'b1;
            else if (align_clr)                  sticky_q <= 1'b0;
        end
    end
endmodule

// File: rtl/be_mem_port_chk.sv
module be_mem_port_chk #(
    parameter logic [31:0] IO0_BASE  = 32'h0000_4000,
    parameter int unsigned IO0_BYTES = 256,
    parameter logic [31:0] IO1_BASE  = 32'h0000_1300,
    parameter int unsigned IO1_BYTES = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [31:0] rsp_rdata,
    input logic        align_clr,
    input logic        align_sticky,
    input logic        io_valid,
    input logic [31:0] io_addr,
    input logic [5:0]  io_size
);
    logic in_win;
    always_comb
        in_win = ((io_addr >= IO0_BASE) && ({1'b0, io_addr} < 33'(IO0_BASE) + 33'(IO0_BYTES))) ||
                 ((io_addr >= IO1_BASE) && ({1'b0, io_addr} < 33'(IO1_BASE) + 33'(IO1_BYTES)));

    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    p_fault_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_rdata == 32'h0));
    p_sticky_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(align_sticky) |-> (rsp_valid && rsp_fault));
    p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (align_sticky && !align_clr) |=> align_sticky);
    p_sticky_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(align_sticky) |-> $past(align_clr));
    p_io_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> in_win);
    p_io_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> (io_size == 6'd8 || io_size == 6'd16 || io_size == 6'd32));
    p_io_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> (!req_ready && !rsp_valid));
endmodule

bind be_mem_port be_mem_port_chk #(
    .IO0_BASE(IO0_BASE), .IO0_BYTES(IO0_BYTES),
    .IO1_BASE(IO1_BASE), .IO1_BYTES(IO1_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata), .align_clr(align_clr),
    .align_sticky(align_sticky), .io_valid(io_valid), .io_addr(io_addr),
    .io_size(io_size)
);

// File: tb/be_mem_port_tb.sv
`timescale 1ns/1ps
module be_mem_port_tb_top;
    localparam logic [31:0] RAM_B = 32'h1000, IO0_B = 32'h4000, IO1_B = 32'h1300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, align_clr = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic req_ready, rsp_valid, rsp_fault, align_sticky, io_valid, io_write;
    logic [31:0] rsp_rdata, io_addr, io_wdata, io_rdata;
    logic [5:0]  io_size;

    always #4 clk = ~clk;

    assign io_rdata = {io_addr[15:0] ^ 16'hA5A5, io_addr[15:0]};

    be_mem_port dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_rdata(rsp_rdata), .align_clr(align_clr), .align_sticky(align_sticky),
        .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_size(io_size), .io_rdata(io_rdata)
    );

    int checks = 0, fails = 0, cyc = 0;
    logic [31:0] ram_m [256];
    logic        exp_sticky = 1'b0;
    logic [31:0] r_data, r_io_addr, r_io_wdata;
    logic        r_fault, r_io, r_io_write;
    logic [5:0]  r_io_size;
    int          r_lat;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // 0 none, 1 rom, 2 ram, 3 io
    function automatic int region_of(logic [31:0] a);
        if ((a >= IO0_B && a < IO0_B + 256) || (a >= IO1_B && a < IO1_B + 256)) return 3;
        if (a < 256) return 1;
        if (a >= RAM_B && a < RAM_B + 1024) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] pick(logic [1:0] sz, logic [1:0] off, logic [31:0] w);
        if (sz == 2'd0) return {24'h0, w[31 - 8*off -: 8]};
        if (sz == 2'd1) return off[1] ? {16'h0, w[15:0]} : {16'h0, w[31:16]};
        return w;
    endfunction

    function automatic logic [31:0] put(logic [1:0] sz, logic [1:0] off, logic [31:0] w, logic [31:0] d);
        logic [31:0] m = w;
        if (sz == 2'd0) m[31 - 8*off -: 8] = d[7:0];
        else if (sz == 2'd1) begin
            if (off[1]) m[15:0] = d[15:0]; else m[31:16] = d[15:0];
        end else m = d;
        return m;
    endfunction

    function automatic logic [31:0] msk(logic [1:0] sz);
        return sz == 2'd0 ? 32'hFF : (sz == 2'd1 ? 32'hFFFF : 32'hFFFF_FFFF);
    endfunction

    task automatic do_req(input logic w, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
        r_io = 1'b0; r_lat = 0;
        @(negedge clk);
        req_valid = 1'b0; r_lat = 1;
        while (!rsp_valid && r_lat < 20) begin
            if (io_valid) begin
                r_io = 1'b1; r_io_addr = io_addr; r_io_size = io_size;
                r_io_wdata = io_wdata; r_io_write = io_write;
            end
            @(negedge clk); r_lat++;
        end
        r_data = rsp_rdata; r_fault = rsp_fault;
        @(negedge clk);
        chk("R11 pulse/ready", {30'h0, rsp_valid, req_ready}, 32'h1);
    endtask

    task automatic run_op(input logic w, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
        logic mis;
        int rg, exp_lat;
        logic [31:0] exp_d;
        logic [7:0]  idx;
        string tag;
        mis = ((sz >= 2'd2) && a[1:0] != 2'b00) || (sz == 2'd1 && a[0]);
        rg  = region_of(a);
        idx = 8'((a - RAM_B) >> 2);
        exp_d = 32'h0; exp_lat = 2;
        if (mis) begin
            tag = "R2 misaligned"; exp_sticky = 1'b1;
        end else if (rg == 3) begin
            tag = "R9 io";
            if (!w) exp_d = {a[15:0] ^ 16'hA5A5, a[15:0]} & msk(sz);
        end else if (rg == 1) begin
            tag = w ? "R7 rom write" : (sz == 0 ? "R4 rom byte" : (sz == 1 ? "R5 rom half" : "R7 rom word"));
            if (!w) begin exp_lat = 3; exp_d = pick(sz, a[1:0], 32'hC0DE_0000 | (a >> 2)); end
        end else if (rg == 2) begin
            exp_lat = 3;
            tag = w ? "R6 ram write" : (sz == 0 ? "R4 ram byte" : (sz == 1 ? "R5 ram half" : "R8 ram word"));
            if (!w) exp_d = pick(sz, a[1:0], ram_m[idx]);
            else ram_m[idx] = put(sz, a[1:0], ram_m[idx], d);
        end else tag = "R10 unmapped";
        do_req(w, sz, a, d);
        chk({tag, " data"}, r_data, exp_d);
        chk({tag, " fault"}, {31'h0, r_fault}, {31'h0, mis});
        chk("R11 latency", r_lat, exp_lat);
        chk("R3 sticky", {31'h0, align_sticky}, {31'h0, exp_sticky});
        chk("R9 io strobe", {31'h0, r_io}, {31'h0, (!mis && rg == 3)});
        if (r_io) begin
            chk("R9 io addr", r_io_addr, a);
            chk("R9 io size", {26'h0, r_io_size}, sz == 0 ? 8 : (sz == 1 ? 16 : 32));
            chk("R9 io wdata", r_io_wdata, d & msk(sz));
            chk("R9 io dir", {31'h0, r_io_write}, {31'h0, w});
        end
    endtask

    task automatic clear_sticky();
        @(negedge clk); align_clr = 1'b1;
        @(negedge clk); align_clr = 1'b0;
        exp_sticky = 1'b0;
        chk("R3 cleared", {31'h0, align_sticky}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ready", {31'h0, req_ready}, 32'h1);
        chk("R1 reset idle outputs", {29'h0, rsp_valid, io_valid, align_sticky}, 32'h0);

        // fill reachable RAM (words below the device overlap)
        for (int i = 0; i < 192; i++)
            run_op(1'b1, 2'd2, RAM_B + 32'(i * 4), $urandom);

        // directed lanes
        run_op(1'b1, 2'd2, 32'h1010, 32'h1122_3344);
        for (int k = 0; k < 4; k++) run_op(1'b0, 2'd0, 32'h1010 + 32'(k), 0);
        run_op(1'b0, 2'd1, 32'h1010, 0);
        run_op(1'b0, 2'd1, 32'h1012, 0);
        run_op(1'b1, 2'd0, 32'h1011, 32'hFFFF_FFAB);   // R6 byte merge
        run_op(1'b1, 2'd1, 32'h1012, 32'h0000_CDEF);   // R6 half merge
        run_op(1'b0, 2'd2, 32'h1010, 0);
        // ROM read and dropped write
        run_op(1'b0, 2'd2, 32'h0000_0024, 0);
        run_op(1'b1, 2'd2, 32'h0000_0024, 32'hDEAD_BEEF);
        run_op(1'b0, 2'd2, 32'h0000_0024, 0);
        run_op(1'b0, 2'd0, 32'h0000_00FF, 0);
        // unmapped
        run_op(1'b1, 2'd2, 32'h0000_2000, 32'h1234_5678);
        run_op(1'b0, 2'd2, 32'h0000_2000, 0);
        // misaligned word write must not touch memory
        run_op(1'b1, 2'd2, 32'h1022, 32'h5555_5555);
        run_op(1'b0, 2'd2, 32'h1020, 0);
        run_op(1'b0, 2'd1, 32'h1021, 0);
        run_op(1'b1, 2'd3, 32'h4001, 32'h1);           // misaligned device: no strobe
        run_op(1'b0, 2'd0, 32'h1023, 0);               // R2 byte never faults
        clear_sticky();
        // device windows, including overlap with RAM
        run_op(1'b0, 2'd1, 32'h4012, 0);
        run_op(1'b1, 2'd0, 32'h1305, 32'hFFFF_FF9C);
        run_op(1'b0, 2'd2, 32'h13FC, 0);

        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            int p = $urandom % 10;
            if (p < 6)       a = RAM_B + ($urandom % 32'h300);
            else if (p == 6) a = $urandom % 256;
            else if (p == 7) a = IO0_B + ($urandom % 256);
            else if (p == 8) a = IO1_B + ($urandom % 256);
            else             a = 32'h2000 + ($urandom % 32'h1000);
            run_op(1'($urandom), 2'($urandom), a, $urandom);
            if ($urandom % 16 == 0) clear_sticky();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule